// File: doc/BRIEF.md
# SDRAM Periodic Refresh Scheduler

This block keeps an SDR SDRAM array refreshed without software help. A saturating elapsed-clock counter compares against a programmed interval. When the interval has run out, a refresh-due flag is raised. The flag stays set until a refresh is actually issued. While the flag is set, or while a refresh sequence is in flight, the block raises a hold-off line. The access engine uses that line to withhold the acknowledge of any new read or write request.

The block waits for the access engine to report that no data burst is in progress. It then takes the command bus. If any bank is still open, it first issues a precharge-all (A10 high) and waits tRP clocks. It then issues the auto-refresh command to every chip select at once. It holds the bus for tRFC clocks and finally pulses a done strobe. The elapsed counter restarts on the auto-refresh cycle itself, so late service never shortens or stretches the following period.

The controller is a Moore machine with six states:
- IDLE: the bus is free.
- PRECH_ALL: the precharge-all command cycle.
- WAIT_RP: precharge recovery.
- AUTO_REF: the auto-refresh command cycle.
- WAIT_RFC: refresh recovery.
- DONE: a one-cycle completion strobe.

Its transitions are:
- IDLE goes to PRECH_ALL when refresh is due, no burst is running and a bank is open.
- IDLE goes to AUTO_REF on the same conditions with every bank closed.
- PRECH_ALL goes to AUTO_REF when tRP is 1, and to WAIT_RP otherwise.
- WAIT_RP goes to AUTO_REF when its timer reaches its last cycle.
- AUTO_REF goes to DONE when tRFC is 1 or less, and to WAIT_RFC otherwise.
- WAIT_RFC goes to DONE on the timer's last cycle.
- DONE always returns to IDLE.

Top module: `sdr_refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the command outputs encode a no-operation (ras_n, cas_n and we_n all 1), every chip select is high, and hold-off, bus ownership and done are 0.
- R2: With the interval register set to I, refresh becomes due I-1 cycles after reset release. With no burst and all banks closed, the first auto-refresh appears in cycle I.
- R3: No precharge-all or auto-refresh command is issued in any cycle where burst_busy is 1, or in the cycle right after one with burst_busy 1. Once a due refresh sees burst_busy low, its first command follows in the next cycle.
- R4: Hold-off rises in the cycle refresh becomes due and stays high continuously until the done cycle, in which it is 0.
- R5: When bank_open_any is 1 at arbitration, a precharge-all is issued first, encoded ras_n=0, cas_n=1, we_n=0 with A10=1. The auto-refresh follows exactly tRP cycles later, for tRP from 1 to 4.
- R6: When bank_open_any is 0 at arbitration, no precharge is issued and the auto-refresh is the first command.
- R7: Auto-refresh is encoded ras_n=0, cas_n=0, we_n=1. Every command cycle drives all chip selects low together.
- R8: The done strobe is high for exactly one cycle, tRFC cycles after the auto-refresh, for tRFC from 2 to 14. No command is issued in between.
- R9: A due condition that persists across a long burst yields exactly one refresh. The next sequence begins exactly I cycles after the previous auto-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interval | input | CNT_W (16) | Refresh period in clocks (10 to 65535) |
| cfg_trp | input | RP_W (3) | Precharge recovery in clocks (1 to 4) |
| cfg_trfc | input | RFC_W (4) | Refresh recovery in clocks (2 to 14) |
| bank_open_any | input | 1 | At least one bank is open |
| burst_busy | input | 1 | Access engine is inside a data burst |
| ref_hold | output | 1 | Withhold acknowledge of new requests |
| ref_owns_bus | output | 1 | Command mux selects this block |
| ref_cs_n | output | NUM_CS (8) | Chip selects, active low |
| ref_ras_n | output | 1 | Row strobe command bit |
| ref_cas_n | output | 1 | Column strobe command bit |
| ref_we_n | output | 1 | Write enable command bit |
| ref_a10 | output | 1 | Address bit 10 (all-bank select) |
| ref_done | output | 1 | One-cycle refresh completion strobe |

## Verification
The bench keeps the default widths: a 16-bit interval, 3- and 4-bit recovery fields and eight chip selects. It programs short intervals of 10 to 30 clocks, so two full refresh periods fit in a few dozen cycles. The tRP values span the full range of 1 to 4, which includes the direct PRECH_ALL to AUTO_REF path. The tRFC values reach both ends, 2 and 14. Some scenarios hold burst_busy far past the due point, which exercises both the postponed arbitration and the single-refresh, no-drift behaviour.

// File: rtl/sdr_ref_pkg.sv
package sdr_ref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECH_ALL,
        ST_WAIT_RP,
        ST_AUTO_REF,
        ST_WAIT_RFC,
        ST_DONE
    } ref_state_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP     = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_PRECH   = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdr_cmd_t CMD_AUTOREF = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/sdr_ref_interval.sv
module sdr_ref_interval #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic             restart,
    output logic             due
);
    logic [CNT_W-1:0] elapsed_q;
    logic [CNT_W-1:0] limit;

    assign limit = cfg_interval - CNT_W'(1);
    assign due   = (elapsed_q >= limit);

    // Saturates at the limit so a late service never queues a second refresh.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (restart) begin
            elapsed_q <= CNT_W'(1);
        end else if (!due) begin
            elapsed_q <= elapsed_q + CNT_W'(1);
        end
    end

    assert_restart_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (elapsed_q == CNT_W'(1)));

    assert_due_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !restart && $stable(cfg_interval)) |=> due);

endmodule

// File: rtl/sdr_ref_wait.sv
module sdr_ref_wait #(
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             last
);
    logic [TMR_W-1:0] remain_q;

    assign last = (remain_q <= TMR_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - TMR_W'(1);
        end
    end

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && remain_q == '0) |=> (remain_q == '0));

endmodule

// File: rtl/sdr_ref_fsm.sv
module sdr_ref_fsm
    import sdr_ref_pkg::*;
#(
    parameter int RP_W   = 3,
    parameter int RFC_W  = 4,
    parameter int TMR_W  = 4,
    parameter int NUM_CS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              due,
    input  logic              burst_busy,
    input  logic              bank_open_any,
    input  logic [RP_W-1:0]   cfg_trp,
    input  logic [RFC_W-1:0]  cfg_trfc,
    input  logic              tmr_last,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    output logic              restart,
    output logic              ref_hold,
    output logic              ref_owns_bus,
    output logic [NUM_CS-1:0] ref_cs_n,
    output logic              ref_ras_n,
    output logic              ref_cas_n,
    output logic              ref_we_n,
    output logic              ref_a10,
    output logic              ref_done
);
    ref_state_t state_q, state_d;
    sdr_cmd_t   cmd;
    logic       cs_active;
    logic       trp_short, trfc_short;

    assign trp_short  = (cfg_trp  <= RP_W'(1));
    assign trfc_short = (cfg_trfc <= RFC_W'(1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (due && !burst_busy) begin
                    state_d = bank_open_any ? ST_PRECH_ALL : ST_AUTO_REF;
                end
            end
            ST_PRECH_ALL: state_d = trp_short ? ST_AUTO_REF : ST_WAIT_RP;
            ST_WAIT_RP:   if (tmr_last) state_d = ST_AUTO_REF;
            ST_AUTO_REF:  state_d = trfc_short ? ST_DONE : ST_WAIT_RFC;
            ST_WAIT_RFC:  if (tmr_last) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore outputs
    always_comb begin
        cmd          = CMD_NOP;
        cs_active    = 1'b0;
        ref_a10      = 1'b0;
        ref_owns_bus = 1'b0;
        ref_done     = 1'b0;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        restart      = 1'b0;
        ref_hold     = due;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRECH_ALL: begin
                cmd          = CMD_PRECH;
                cs_active    = 1'b1;
                ref_a10      = 1'b1;
                ref_owns_bus = 1'b1;
                ref_hold     = 1'b1;
                tmr_load     = 1'b1;
                tmr_val      = TMR_W'(cfg_trp) - TMR_W'(1);
            end
            ST_WAIT_RP: begin
                ref_owns_bus = 1'b1;
                ref_hold     = 1'b1;
            end
            ST_AUTO_REF: begin
                cmd          = CMD_AUTOREF;
                cs_active    = 1'b1;
                ref_owns_bus = 1'b1;
                ref_hold     = 1'b1;
                restart      = 1'b1;
                tmr_load     = 1'b1;
                tmr_val      = TMR_W'(cfg_trfc) - TMR_W'(1);
            end
            ST_WAIT_RFC: begin
                ref_owns_bus = 1'b1;
                ref_hold     = 1'b1;
            end
            ST_DONE: begin
                ref_done = 1'b1;
                ref_hold = 1'b0;
            end
            default: ;
        endcase
    end

    assign ref_ras_n = cmd.ras_n;
    assign ref_cas_n = cmd.cas_n;
    assign ref_we_n  = cmd.we_n;

    // The command reaches every chip select in the same cycle.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs_fanout
        assign ref_cs_n[g] = ~cs_active;
    end

    assert_no_cmd_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && burst_busy) |=>
            !(state_q inside {ST_PRECH_ALL, ST_AUTO_REF}));

    assert_prech_needs_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRECH_ALL) |-> $past(bank_open_any));

    assert_closed_skips_prech_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && due && !burst_busy && !bank_open_any) |=>
            (state_q == ST_AUTO_REF));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |=> !ref_done);

    assert_hold_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_hold) |-> ref_done);

endmodule

// File: rtl/sdr_refresh_sched.sv
module sdr_refresh_sched
    import sdr_ref_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int RP_W   = 3,
    parameter int RFC_W  = 4,
    parameter int NUM_CS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_interval,
    input  logic [RP_W-1:0]   cfg_trp,
    input  logic [RFC_W-1:0]  cfg_trfc,
    input  logic              bank_open_any,
    input  logic              burst_busy,
    output logic              ref_hold,
    output logic              ref_owns_bus,
    output logic [NUM_CS-1:0] ref_cs_n,
    output logic              ref_ras_n,
    output logic              ref_cas_n,
    output logic              ref_we_n,
    output logic              ref_a10,
    output logic              ref_done
);
    localparam int TMR_W = (RP_W > RFC_W) ? RP_W : RFC_W;

    logic             due;
    logic             restart;
    logic             tmr_load;
    logic             tmr_last;
    logic [TMR_W-1:0] tmr_val;

    sdr_ref_interval #(.CNT_W(CNT_W)) u_interval (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_interval (cfg_interval),
        .restart      (restart),
        .due          (due)
    );

    sdr_ref_wait #(.TMR_W(TMR_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sdr_ref_fsm #(
        .RP_W   (RP_W),
        .RFC_W  (RFC_W),
        .TMR_W  (TMR_W),
        .NUM_CS (NUM_CS)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .due           (due),
        .burst_busy    (burst_busy),
        .bank_open_any (bank_open_any),
        .cfg_trp       (cfg_trp),
        .cfg_trfc      (cfg_trfc),
        .tmr_last      (tmr_last),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .restart       (restart),
        .ref_hold      (ref_hold),
        .ref_owns_bus  (ref_owns_bus),
        .ref_cs_n      (ref_cs_n),
        .ref_ras_n     (ref_ras_n),
        .ref_cas_n     (ref_cas_n),
        .ref_we_n      (ref_we_n),
        .ref_a10       (ref_a10),
        .ref_done      (ref_done)
    );

    assert_cmd_all_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_ras_n) |-> (ref_cs_n == '0 && ref_owns_bus));

    assert_refresh_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_done) |-> !$past(ref_ras_n) || $past(ref_owns_bus));

endmodule

// File: tb/sdr_refresh_sched_bench.sv
`timescale 1ns/1ps
module sdr_refresh_sched_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_interval = 16'd20;
    logic [2:0]  cfg_trp = 3'd2;
    logic [3:0]  cfg_trfc = 4'd4;
    logic        bank_open_any = 1'b0;
    logic        burst_busy = 1'b0;
    logic        ref_hold, ref_owns_bus, ref_ras_n, ref_cas_n, ref_we_n, ref_a10, ref_done;
    logic [7:0]  ref_cs_n;

    int checks = 0;
    int errors = 0;
    int wd = 0;

    always #10 clk = ~clk;

    sdr_refresh_sched u_sdr_refresh_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_interval  (cfg_interval),
        .cfg_trp       (cfg_trp),
        .cfg_trfc      (cfg_trfc),
        .bank_open_any (bank_open_any),
        .burst_busy    (burst_busy),
        .ref_hold      (ref_hold),
        .ref_owns_bus  (ref_owns_bus),
        .ref_cs_n      (ref_cs_n),
        .ref_ras_n     (ref_ras_n),
        .ref_cas_n     (ref_cas_n),
        .ref_we_n      (ref_we_n),
        .ref_a10       (ref_a10),
        .ref_done      (ref_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Vector layout: interval[31:16] trp[15:13] trfc[12:9] open[8] busy_cycles[7:0]
    localparam logic [31:0] VEC [6] = '{
        {16'd20, 3'd2, 4'd4,  1'b0, 8'd0},
        {16'd20, 3'd3, 4'd7,  1'b1, 8'd0},
        {16'd12, 3'd1, 4'd2,  1'b1, 8'd0},
        {16'd30, 3'd4, 4'd14, 1'b1, 8'd40},
        {16'd16, 3'd2, 4'd3,  1'b0, 8'd25},
        {16'd10, 3'd2, 4'd5,  1'b0, 8'd5}
    };

    task automatic run_vec(input logic [31:0] v);
        int iv, rp, rfc, bsy, arb, t_first, t_ar, t_done, t_ar2, last_c;
        int n_ar, n_pre, n_done, n_bad_cs, n_bad_a10, n_busy_cmd;
        int first_ar, first_pre, first_done, second_ar, hold_rise, hold_fall;
        bit op;
        iv  = int'(v[31:16]);
        rp  = int'(v[15:13]);
        rfc = int'(v[12:9]);
        op  = v[8];
        bsy = int'(v[7:0]);
        arb     = (iv - 1 > bsy) ? iv - 1 : bsy;
        t_first = arb + 1;
        t_ar    = t_first + (op ? rp : 0);
        t_done  = t_ar + rfc;
        t_ar2   = t_ar + iv + (op ? rp : 0);
        last_c  = t_ar2 + rfc + 3;
        n_ar = 0; n_pre = 0; n_done = 0; n_bad_cs = 0; n_bad_a10 = 0; n_busy_cmd = 0;
        first_ar = -1; first_pre = -1; first_done = -1; second_ar = -1;
        hold_rise = -1; hold_fall = -1;

        @(negedge clk);
        rst_n = 1'b0;
        cfg_interval = v[31:16];
        cfg_trp = v[15:13];
        cfg_trfc = v[12:9];
        bank_open_any = op;
        burst_busy = (bsy > 0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c <= last_c; c++) begin
            burst_busy = (c < bsy);
            if (!ref_ras_n) begin
                if (ref_cs_n != 8'h00) n_bad_cs++;
                if (burst_busy || (c > 0 && c <= bsy)) n_busy_cmd++;
            end
            if (!ref_ras_n && !ref_cas_n && ref_we_n) begin
                n_ar++;
                if (first_ar < 0) first_ar = c; else if (second_ar < 0) second_ar = c;
            end
            if (!ref_ras_n && ref_cas_n && !ref_we_n) begin
                n_pre++;
                if (!ref_a10) n_bad_a10++;
                if (first_pre < 0) first_pre = c;
            end
            if (ref_done) begin
                n_done++;
                if (first_done < 0) first_done = c;
            end
            if (ref_hold && hold_rise < 0) hold_rise = c;
            if (!ref_hold && hold_rise >= 0 && hold_fall < 0) hold_fall = c;
            @(negedge clk);
        end

        check(hold_rise == iv - 1, "R2 due cycle", hold_rise, iv - 1);
        check(first_ar == t_ar, "R2/R3 first auto-refresh cycle", first_ar, t_ar);
        check(n_busy_cmd == 0, "R3 command during burst", n_busy_cmd, 0);
        check(hold_fall == t_done, "R4 hold-off release cycle", hold_fall, t_done);
        if (op) begin
            check(first_pre == t_first, "R5 precharge-all cycle", first_pre, t_first);
            check(first_ar - first_pre == rp, "R5 tRP spacing", first_ar - first_pre, rp);
            check(n_bad_a10 == 0, "R5 A10 on precharge-all", n_bad_a10, 0);
            check(n_pre == 2, "R5 precharge count", n_pre, 2);
        end else begin
            check(n_pre == 0, "R6 no precharge with banks closed", n_pre, 0);
        end
        check(n_bad_cs == 0, "R7 all chip selects on command", n_bad_cs, 0);
        check(first_done == t_done, "R8 done after tRFC", first_done, t_done);
        check(n_done == 2, "R8 single-cycle done strobes", n_done, 2);
        check(n_ar == 2, "R9 no queued extra refresh", n_ar, 2);
        check(second_ar == t_ar2, "R9 period restarts at auto-refresh", second_ar, t_ar2);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", wd, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state, and the first cycle after release
        @(negedge clk);
        @(negedge clk);
        check({ref_ras_n, ref_cas_n, ref_we_n} == 3'b111, "R1 NOP in reset",
              int'({ref_ras_n, ref_cas_n, ref_we_n}), 7);
        check(ref_cs_n == 8'hFF, "R1 chip selects high in reset", int'(ref_cs_n), 255);
        check({ref_hold, ref_owns_bus, ref_done} == 3'b000, "R1 status low in reset",
              int'({ref_hold, ref_owns_bus, ref_done}), 0);
        rst_n = 1'b1;
        check({ref_ras_n, ref_cas_n, ref_we_n, ref_hold} == 4'b1110,
              "R1 idle after release", int'({ref_ras_n, ref_cas_n, ref_we_n, ref_hold}), 14);

        for (int i = 0; i < 6; i++) begin
            run_vec(VEC[i]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule